// File: doc/BRIEF.md
# Single-Cycle RV32I Integer Datapath

This block is the datapath of a single-cycle processor for a small RV32I subset: register-register arithmetic, register-immediate arithmetic, word loads (lw) and word stores (sw). Every clock cycle it fetches one instruction from an internal program ROM, reads two source registers, forms the second operand from a register or a sign-extended immediate, runs the ALU, optionally reads or writes a word of data memory, and writes the result back to the register file on the next rising edge.

The control decoder is outside the block. The surrounding logic reads the opcode, funct3 and funct7 fields of the current instruction, which the block drives as outputs. It returns the six control inputs in the same cycle. The ALU result is also an output, so each instruction's effect can be seen at the ports. Register contents become visible when a later instruction copies them through the ALU. All pins are plain control and status signals, and there is no streaming handshake.

Top module: `rv_datapath`

## Requirements
- R1: The 8-bit program counter is cleared while `reset` is high on a rising clock edge. Otherwise it advances by 4 on every rising edge and wraps from 252 to 0.
- R2: The instruction is the ROM word selected by PC[7:2]. `opcode` shows instruction bits [6:0], `funct3` shows bits [14:12] and `funct7` shows bits [31:25]. Word 18 holds 32'h02b02823 (sw x11, 48(x0)) and word 19 holds 32'h03002603 (lw x12, 48(x0)).
- R3: The register file has 32 registers of 32 bits. On a rising edge it writes the write-back value to the register at instruction bits [11:7] when `reg_write` is high. Its two sources, bits [19:15] and bits [24:20], are read combinationally.
- R4: Register x0 always reads as zero, and writes addressed to it have no effect.
- R5: The immediate sign-extends bits [31:20] for opcodes 0000011 and 0010011. For opcode 0100011 it sign-extends {bits [31:25], bits [11:7]}. When `alu_src` is high, the second ALU operand is this immediate. When it is low, the second operand is the second source register.
- R6: `alu_cc` selects the ALU operation: 0000 AND, 0001 OR, 0010 add, 0110 subtract, 0111 signed less-than (1 or 0), 1100 NOR, 1111 equality (1 or 0). Every other code performs an add.
- R7: The data memory holds 128 words of 32 bits. It is indexed by bits [8:2] of the ALU result, so address bits above bit 8 have no effect. It writes the second source register on a rising edge when `mem_write` is high.
- R8: Memory read data is combinational while `mem_read` is high and zero while it is low. When `mem2reg` is high, the write-back value is the memory read data. When it is low, the write-back value is the ALU result.
- R9: For lw and sw with code 0010, the ALU result is the base register plus the signed offset. For example, an offset of 48 from x0 gives 32'h00000030.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| reset | input | 1 | Synchronous active-high clear of the program counter |
| reg_write | input | 1 | Write the write-back value to the destination register |
| mem2reg | input | 1 | Select memory read data (1) or ALU result (0) for write-back |
| alu_src | input | 1 | Select immediate (1) or second source register (0) as ALU operand B |
| mem_write | input | 1 | Store the second source register to data memory |
| mem_read | input | 1 | Drive data memory read data |
| alu_cc | input | 4 | ALU operation code |
| opcode | output | 7 | Instruction bits [6:0] |
| funct7 | output | 7 | Instruction bits [31:25] |
| funct3 | output | 3 | Instruction bits [14:12] |
| alu_result | output | 32 | ALU result of the current instruction |

## Verification
The bench goes after the following corner cases:
- A negative immediate and a negative store offset. A design that zero-extended instead of sign-extending, or that assembled the store offset from the wrong fields, would compute a wrong address, and the later reload would return a wrong value.
- Less-than on operands of mixed sign, which exposes an unsigned comparison.
- A write aimed at x0, followed by a read of x0, which exposes storage in x0.
- An unused ALU code, which must fall back to add.
- A load at an address above bit 8, which must alias onto a lower word. A design that used more address bits would read a different word.
- Loads that return earlier stores through write-back, which catch a swapped write-back select.
- A mid-run reset and the wrap of the program counter past its last word.

// File: rtl/rv_dp_pkg.sv
`timescale 1ns / 1ps
package rv_dp_pkg;

  localparam int INSTR_W = 32;

  // Major opcodes handled by the datapath
  localparam logic [6:0] OPC_RR   = 7'b0110011;
  localparam logic [6:0] OPC_ARI  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD = 7'b0000011;
  localparam logic [6:0] OPC_STOR = 7'b0100011;

  // ALU operation codes
  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;
  localparam logic [3:0] ALU_NOR = 4'b1100;
  localparam logic [3:0] ALU_EQ  = 4'b1111;

  localparam logic [INSTR_W-1:0] INSTR_NOP = 32'h00000013;

  function automatic logic [INSTR_W-1:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                               input logic [4:0] rs1, input logic [2:0] f3,
                                               input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_RR};
  endfunction

  function automatic logic [INSTR_W-1:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                               input logic [2:0] f3, input logic [4:0] rd,
                                               input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [INSTR_W-1:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                               input logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], OPC_STOR};
  endfunction

endpackage

// File: rtl/rv_fetch.sv
`timescale 1ns / 1ps
module rv_fetch
  import rv_dp_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic               clk,
  input  logic               reset,
  output logic [PC_W-1:0]    pc,
  output logic [INSTR_W-1:0] instr
);
  localparam int WIDX_W = PC_W - 2;

  logic [WIDX_W-1:0] widx;

  always_ff @(posedge clk) begin
    if (reset) pc <= '0;
    else       pc <= pc + PC_W'(4);
  end

  assign widx = pc[PC_W-1:2];

  // Program image computed from word index; unused words are no-ops
  function automatic logic [INSTR_W-1:0] rom_word(input int w);
    case (w)
      0:  return enc_i(12'd3,   5'd0,  3'b000, 5'd1,  OPC_ARI);
      1:  return enc_i(12'hFF8, 5'd0,  3'b000, 5'd2,  OPC_ARI);
      2:  return enc_r(7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3);
      3:  return enc_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd4);
      4:  return enc_r(7'b0000000, 5'd2, 5'd1, 3'b111, 5'd5);
      5:  return enc_r(7'b0000000, 5'd2, 5'd1, 3'b110, 5'd6);
      6:  return enc_r(7'b0000000, 5'd1, 5'd2, 3'b010, 5'd7);
      7:  return enc_r(7'b0000000, 5'd2, 5'd1, 3'b010, 5'd8);
      8:  return enc_r(7'b0000000, 5'd2, 5'd1, 3'b100, 5'd9);
      9:  return enc_i(12'h010, 5'd1,  3'b110, 5'd10, OPC_ARI);
      10: return enc_i(12'd5,   5'd0,  3'b000, 5'd11, OPC_ARI);
      11: return enc_r(7'b0000000, 5'd1, 5'd1, 3'b011, 5'd15);
      12: return enc_r(7'b0000000, 5'd2, 5'd1, 3'b011, 5'd16);
      13: return enc_i(12'hFF9, 5'd2,  3'b010, 5'd17, OPC_ARI);
      14: return enc_i(12'd7,   5'd0,  3'b000, 5'd0,  OPC_ARI);
      15: return enc_r(7'b0000000, 5'd0, 5'd0, 3'b000, 5'd18);
      16: return enc_r(7'b0100000, 5'd1, 5'd0, 3'b000, 5'd19);
      17: return enc_i(12'hFFF, 5'd2,  3'b111, 5'd21, OPC_ARI);
      18: return 32'h02b02823;
      19: return 32'h03002603;
      20: return enc_r(7'b0000000, 5'd0, 5'd12, 3'b000, 5'd13);
      21: return enc_i(12'd100, 5'd0,  3'b000, 5'd22, OPC_ARI);
      22: return enc_s(12'hFDC, 5'd3, 5'd22);
      23: return enc_i(12'h040, 5'd0,  3'b010, 5'd23, OPC_LOAD);
      24: return enc_r(7'b0000000, 5'd0, 5'd23, 3'b000, 5'd24);
      25: return enc_i(12'h230, 5'd0,  3'b010, 5'd25, OPC_LOAD);
      26: return enc_r(7'b0000000, 5'd0, 5'd25, 3'b000, 5'd26);
      27: return enc_r(7'b0000000, 5'd2, 5'd1, 3'b001, 5'd27);
      default: return INSTR_NOP;
    endcase
  endfunction

  always_comb instr = rom_word(int'(widx));

endmodule

// File: rtl/rv_regfile.sv
`timescale 1ns / 1ps
module rv_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int NREG = 2 ** ADDR_W;

  logic [DATA_W-1:0] regs [NREG];

  // Slot zero is never written; reads of it are forced to zero
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/rv_alu.sv
`timescale 1ns / 1ps
module rv_alu
  import rv_dp_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ALU_CC_W = 4
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [ALU_CC_W-1:0] cc,
  output logic [DATA_W-1:0]   result
);
  always_comb begin
    if      (cc == ALU_CC_W'(ALU_AND)) result = op_a & op_b;
    else if (cc == ALU_CC_W'(ALU_OR))  result = op_a | op_b;
    else if (cc == ALU_CC_W'(ALU_SUB)) result = op_a - op_b;
    else if (cc == ALU_CC_W'(ALU_SLT)) result = DATA_W'($signed(op_a) < $signed(op_b));
    else if (cc == ALU_CC_W'(ALU_NOR)) result = ~(op_a | op_b);
    else if (cc == ALU_CC_W'(ALU_EQ))  result = DATA_W'(op_a == op_b);
    else                               result = op_a + op_b;
  end

endmodule

// File: rtl/rv_dmem.sv
`timescale 1ns / 1ps
module rv_dmem #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int NWORDS = 2 ** IDX_W;

  logic [DATA_W-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[widx] <= wdata;
  end

  assign rdata = rd_en ? mem[widx] : '0;

endmodule

// File: rtl/rv_datapath.sv
`timescale 1ns / 1ps
module rv_datapath
  import rv_dp_pkg::*;
#(
  parameter int PC_W      = 8,
  parameter int RF_ADDR_W = 5,
  parameter int DATA_W    = 32,
  parameter int DM_ADDR_W = 9,
  parameter int ALU_CC_W  = 4
) (
  input  logic                clk,
  input  logic                reset,
  input  logic                reg_write,
  input  logic                mem2reg,
  input  logic                alu_src,
  input  logic                mem_write,
  input  logic                mem_read,
  input  logic [ALU_CC_W-1:0] alu_cc,
  output logic [6:0]          opcode,
  output logic [6:0]          funct7,
  output logic [2:0]          funct3,
  output logic [DATA_W-1:0]   alu_result
);
  localparam int DM_IDX_W = DM_ADDR_W - 2;
  localparam int IMM_W    = 12;

  logic [PC_W-1:0]      pc_q;
  logic [INSTR_W-1:0]   instr;
  logic [RF_ADDR_W-1:0] rd_idx, rs1_idx, rs2_idx;
  logic [DATA_W-1:0]    rs1_val, rs2_val, imm_val, opb, wb_val, dm_rdata;
  logic [IMM_W-1:0]     imm_raw;

  rv_fetch #(.PC_W(PC_W)) fetch_i (
    .clk(clk), .reset(reset), .pc(pc_q), .instr(instr)
  );

  assign opcode  = instr[6:0];
  assign funct3  = instr[14:12];
  assign funct7  = instr[31:25];
  assign rd_idx  = instr[7 +: RF_ADDR_W];
  assign rs1_idx = instr[15 +: RF_ADDR_W];
  assign rs2_idx = instr[20 +: RF_ADDR_W];

  rv_regfile #(.ADDR_W(RF_ADDR_W), .DATA_W(DATA_W)) rf_i (
    .clk(clk), .we(reg_write), .waddr(rd_idx), .wdata(wb_val),
    .raddr_a(rs1_idx), .raddr_b(rs2_idx), .rdata_a(rs1_val), .rdata_b(rs2_val)
  );

  // Immediate: store format splits the offset around the rd field
  always_comb begin
    if (opcode == OPC_STOR) imm_raw = {instr[31:25], instr[11:7]};
    else                    imm_raw = instr[31:20];
    imm_val = DATA_W'($signed(imm_raw));
  end

  assign opb = alu_src ? imm_val : rs2_val;

  rv_alu #(.DATA_W(DATA_W), .ALU_CC_W(ALU_CC_W)) alu_i (
    .op_a(rs1_val), .op_b(opb), .cc(alu_cc), .result(alu_result)
  );

  rv_dmem #(.IDX_W(DM_IDX_W), .DATA_W(DATA_W)) dmem_i (
    .clk(clk), .wr_en(mem_write), .rd_en(mem_read),
    .widx(alu_result[DM_ADDR_W-1:2]), .wdata(rs2_val), .rdata(dm_rdata)
  );

  assign wb_val = mem2reg ? dm_rdata : alu_result;

endmodule

// File: rtl/rv_datapath_chk.sv
`timescale 1ns / 1ps
module rv_datapath_chk #(
  parameter int PC_W      = 8,
  parameter int RF_ADDR_W = 5,
  parameter int DATA_W    = 32,
  parameter int ALU_CC_W  = 4
) (
  input logic                 clk,
  input logic                 reset,
  input logic [PC_W-1:0]      pc,
  input logic [ALU_CC_W-1:0]  alu_cc,
  input logic                 alu_src,
  input logic                 mem_read,
  input logic [RF_ADDR_W-1:0] rs1_idx,
  input logic [DATA_W-1:0]    rs1_val,
  input logic [DATA_W-1:0]    rs2_val,
  input logic [DATA_W-1:0]    alu_result,
  input logic [DATA_W-1:0]    dm_rdata
);
  // R1
  pc_reset_chk: assert property (@(posedge clk) reset |=> (pc == '0));

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (reset)
    !$past(reset) |-> (pc == PC_W'($past(pc) + PC_W'(4))));

  // R4
  x0_zero_chk: assert property (@(posedge clk) disable iff (reset)
    (rs1_idx == '0) |-> (rs1_val == '0));

  // R6
  reg_add_chk: assert property (@(posedge clk) disable iff (reset)
    ((alu_cc == ALU_CC_W'(4'b0010)) && !alu_src) |-> (alu_result == rs1_val + rs2_val));

  // R8
  dm_idle_chk: assert property (@(posedge clk) disable iff (reset)
    !mem_read |-> (dm_rdata == '0));
endmodule

bind rv_datapath rv_datapath_chk #(
  .PC_W(PC_W), .RF_ADDR_W(RF_ADDR_W), .DATA_W(DATA_W), .ALU_CC_W(ALU_CC_W)
) chk_i (
  .clk(clk), .reset(reset), .pc(pc_q), .alu_cc(alu_cc), .alu_src(alu_src),
  .mem_read(mem_read), .rs1_idx(rs1_idx), .rs1_val(rs1_val), .rs2_val(rs2_val),
  .alu_result(alu_result), .dm_rdata(dm_rdata)
);

// File: tb/rv_datapath_tb_top.sv
`timescale 1ns / 1ps
module rv_datapath_tb_top;

  logic        clk = 1'b0;
  logic        reset = 1'b1;
  logic        reg_write, mem2reg, alu_src, mem_write, mem_read;
  logic [3:0]  alu_cc;
  logic [6:0]  opcode, funct7;
  logic [2:0]  funct3;
  logic [31:0] alu_result;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rv_datapath dut_i (
    .clk(clk), .reset(reset), .reg_write(reg_write), .mem2reg(mem2reg),
    .alu_src(alu_src), .mem_write(mem_write), .mem_read(mem_read), .alu_cc(alu_cc),
    .opcode(opcode), .funct7(funct7), .funct3(funct3), .alu_result(alu_result)
  );

  // Bench-side control decode driven from the instruction fields
  localparam logic [6:0] O_RR = 7'b0110011, O_ARI = 7'b0010011;
  localparam logic [6:0] O_LD = 7'b0000011, O_ST = 7'b0100011;

  assign alu_src   = (opcode == O_LD) || (opcode == O_ST) || (opcode == O_ARI);
  assign mem2reg   = (opcode == O_LD);
  assign mem_read  = (opcode == O_LD);
  assign mem_write = (opcode == O_ST);
  assign reg_write = (opcode == O_RR) || (opcode == O_LD) || (opcode == O_ARI);

  always_comb begin
    alu_cc = 4'b0010;
    if (opcode == O_RR || opcode == O_ARI) begin
      if (opcode == O_RR && funct7 == 7'b0100000 && funct3 == 3'b000) alu_cc = 4'b0110;
      else case (funct3)
        3'b111:  alu_cc = 4'b0000;
        3'b110:  alu_cc = 4'b0001;
        3'b100:  alu_cc = 4'b1100;
        3'b010:  alu_cc = 4'b0111;
        3'b011:  alu_cc = 4'b1111;
        3'b001:  alu_cc = 4'b0011; // unused code, must add (R6)
        default: alu_cc = 4'b0010;
      endcase
    end
  end

  // {opcode, expected alu_result} per program word 0..27
  localparam int NROWS = 28;
  localparam logic [38:0] VEC [NROWS] = '{
    {O_ARI, 32'h00000003},  // 0  addi x1 = 3            R5
    {O_ARI, 32'hFFFFFFF8},  // 1  addi x2 = -8           R5 sign extension
    {O_RR,  32'hFFFFFFFB},  // 2  add                    R6
    {O_RR,  32'h0000000B},  // 3  sub                    R6
    {O_RR,  32'h00000000},  // 4  and                    R6
    {O_RR,  32'hFFFFFFFB},  // 5  or                     R6
    {O_RR,  32'h00000001},  // 6  slt -8 < 3             R6 signed
    {O_RR,  32'h00000000},  // 7  slt 3 < -8             R6 signed
    {O_RR,  32'h00000004},  // 8  nor                    R6
    {O_ARI, 32'h00000013},  // 9  ori 0x10               R5
    {O_ARI, 32'h00000005},  // 10 addi x11 = 5           R3
    {O_RR,  32'h00000001},  // 11 eq x1,x1               R6
    {O_RR,  32'h00000000},  // 12 eq x1,x2               R6
    {O_ARI, 32'h00000001},  // 13 slti -8 < -7           R5
    {O_ARI, 32'h00000007},  // 14 addi x0 = 7 (dropped)  R4
    {O_RR,  32'h00000000},  // 15 add x0,x0 reads zero   R4
    {O_RR,  32'hFFFFFFFD},  // 16 sub 0-3                R6
    {O_ARI, 32'hFFFFFFF8},  // 17 andi -1                R5
    {O_ST,  32'h00000030},  // 18 sw x11,48(x0)          R9
    {O_LD,  32'h00000030},  // 19 lw x12,48(x0)          R9
    {O_RR,  32'h00000005},  // 20 x12 copied             R8
    {O_ARI, 32'h00000064},  // 21 addi x22 = 100         R3
    {O_ST,  32'h00000040},  // 22 sw x3,-36(x22)         R5 S-type
    {O_LD,  32'h00000040},  // 23 lw x23,64(x0)          R7
    {O_RR,  32'hFFFFFFFB},  // 24 x23 copied             R7
    {O_LD,  32'h00000230},  // 25 lw x25,560(x0)         R7 aliasing
    {O_RR,  32'h00000005},  // 26 x25 copied             R7
    {O_RR,  32'hFFFFFFFB}   // 27 unused code adds       R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: held in reset, word 0 stays selected
    check("R1 reset holds pc", {25'd0, opcode}, {25'd0, O_ARI});
    check("R1 reset alu", alu_result, 32'h3);
    reset = 1'b0;
    #1;
    for (int w = 0; w < NROWS; w++) begin
      check($sformatf("R2 opcode word %0d", w), {25'd0, opcode}, {25'd0, VEC[w][38:32]});
      check($sformatf("R6 alu_result word %0d", w), alu_result, VEC[w][31:0]);
      if (w == 3) begin
        check("R2 funct7 sub", {25'd0, funct7}, 32'h20);
        check("R2 funct3 sub", {29'd0, funct3}, 32'h0);
      end
      if (w == 18) begin
        check("R2 funct3 sw", {29'd0, funct3}, 32'h2);
        check("R2 funct7 sw", {25'd0, funct7}, 32'h01);
      end
      @(negedge clk);
      #1;
    end
    // R1: run on through the no-op region until the counter wraps to word 0
    for (int w = NROWS; w < 64; w++) begin
      if (w == 40) check("R1 nop region", alu_result, 32'h0);
      @(negedge clk);
      #1;
    end
    check("R1 wrap to word 0", alu_result, 32'h3);
    @(negedge clk); #1;
    @(negedge clk); #1;
    check("R3 word 2 after wrap", alu_result, 32'hFFFFFFFB);
    // R1: mid-run reset returns to word 0
    @(negedge clk);
    reset = 1'b1;
    @(negedge clk);
    reset = 1'b0;
    #1;
    check("R1 mid-run reset", alu_result, 32'h3);
    for (int w = 0; w < 20; w++) begin
      @(negedge clk);
      #1;
    end
    // R8: second pass of word 20 reloads the stored word
    check("R8 reload after reset", alu_result, 32'h5);
    finish_run();
  end

endmodule